// File: doc/BRIEF.md
# Multi-Access Instruction Retirement Sequencer

This block turns a single stack push or pop instruction, which the load/store engine expands into several memory accesses, into a series of trace reports. Each memory access produces one instruction retirement on the instruction trace side. In the same cycle, the block drives the data-trace strobe, access kind, address and size for that access. Every report in a series carries the same instruction address. The type code stays at zero until the final access, and only that final access shows the instruction's natural type, such as a return.

The core starts a series by pulsing `start_i` with these values:
- the instruction address,
- the number of accesses,
- the direction,
- the final type code,
- the base stack address,
- the register width, given as a power-of-two byte code.

The block then issues one access per cycle and holds `busy_o` high while the series runs. A trap raised through `abort_i` drops the series at once and clears the access count. When the instruction is executed again, the core pulses `start_i` again and reporting restarts from the first access.

Top module: `pushpop_trace_seq`

## Requirements
- R1: While reset is held and after it is released with no start, `busy_o`, `iretire_o` and `dretire_o` are all low.
- R2: A start pulse while idle with count N (N >= 1) produces reports in N consecutive cycles, beginning in the cycle after the start edge. `busy_o` is high during all of those cycles and low in the cycle after the last report.
- R3: Each report raises `iretire_o` and `dretire_o` together. `iaddr_o` equals the instruction address captured at start, even if the start inputs change afterwards.
- R4: `itype_o` is 0 on every report except the last one of a series, which carries the captured final type code.
- R5: `dtype_o` is 0 (load) for a pop and 1 (store) for a push. `dsize_o` equals the captured width code, meaning an access of 2^code bytes.
- R6: For access k (counting from 0) with step S = 2^code, the address is base + k*S for a pop and base - (k+1)*S for a push, modulo 2^DADDR_W.
- R7: A start pulse while `busy_o` is high is ignored: the running series continues unchanged.
- R8: A start pulse with count 0 is ignored: `busy_o` stays low and no report appears.
- R9: With `abort_i` high during a series, that cycle shows no report and no final type, and `busy_o` is low in the next cycle. A later start of the same instruction begins again at access 1 and base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for one multi-access instruction |
| start_iaddr_i | input | IADDR_W | Instruction address to report |
| start_count_i | input | CNT_W | Number of memory accesses |
| start_pop_i | input | 1 | 1 = pop (loads, ascending), 0 = push (stores, descending) |
| start_ftype_i | input | ITYPE_W | Natural type code shown on the final access |
| start_base_i | input | DADDR_W | Stack base address |
| start_size_i | input | DSIZE_W | Register width code, 2^code bytes |
| abort_i | input | 1 | Trap abort of the running series |
| busy_o | output | 1 | Series in progress, new starts ignored |
| iretire_o | output | 1 | One instruction retired this cycle |
| iaddr_o | output | IADDR_W | Address of the retired instruction |
| itype_o | output | ITYPE_W | Type code of the retirement |
| dretire_o | output | 1 | Data access retired this cycle |
| dtype_o | output | DTYPE_W | Data access kind, 0 load, 1 store |
| daddr_o | output | DADDR_W | Data access address |
| dsize_o | output | DSIZE_W | Data access size code |

## Verification
The bench runs every access count from 1 to 15 in both directions with all four width codes. This separates off-by-one faults in the last-access detection from faults in the ascending or descending stride and from shift faults in the step size. A push series starting near address zero checks that the address wraps. Start inputs are scrambled right after each start, which shows whether the address and direction were captured. Further runs poke `start_i` during a busy series, start with count zero, and abort both in the middle of a series and on its last access followed by a restart. Together these tell ignored starts apart from restarts and show that the final type is suppressed.

// File: rtl/ppseq_pkg.sv
`timescale 1ns/1ps
package ppseq_pkg;

    typedef enum logic {
        DIR_PUSH = 1'b0,
        DIR_POP  = 1'b1
    } dir_e;

    localparam int unsigned KIND_LOAD  = 0;
    localparam int unsigned KIND_STORE = 1;
    localparam int unsigned TYPE_PLAIN = 0;

endpackage

// File: rtl/ppseq_addr.sv
`timescale 1ns/1ps
module ppseq_addr
    import ppseq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 2
) (
    input  dir_e              start_dir,
    input  logic [SIZE_W-1:0] start_size,
    input  logic [ADDR_W-1:0] base,
    input  dir_e              cur_dir,
    input  logic [SIZE_W-1:0] cur_size,
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] next_addr
);
    logic [ADDR_W-1:0] step_start;
    logic [ADDR_W-1:0] step_cur;

    always_comb begin
        step_start = ADDR_W'(1) << start_size;
        step_cur   = ADDR_W'(1) << cur_size;
        // pop reads from the base upward; push pre-decrements below it
        first_addr = (start_dir == DIR_POP) ? base : (base - step_start);
        next_addr  = (cur_dir == DIR_POP) ? (cur + step_cur) : (cur - step_cur);
    end
endmodule

// File: rtl/ppseq_last.sv
`timescale 1ns/1ps
module ppseq_last #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] done,
    input  logic [CNT_W-1:0] total,
    output logic             is_last
);
    logic [CNT_W-1:0] upcoming;

    always_comb begin
        upcoming = done + CNT_W'(1);
        is_last  = (upcoming == total);
    end
endmodule

// File: rtl/ppseq_report.sv
`timescale 1ns/1ps
module ppseq_report
    import ppseq_pkg::*;
#(
    parameter int IADDR_W = 32,
    parameter int DADDR_W = 32,
    parameter int ITYPE_W = 4,
    parameter int DTYPE_W = 4,
    parameter int DSIZE_W = 2
) (
    input  logic               active,
    input  logic               is_last,
    input  dir_e               dir,
    input  logic [IADDR_W-1:0] iaddr,
    input  logic [ITYPE_W-1:0] ftype,
    input  logic [DADDR_W-1:0] daddr,
    input  logic [DSIZE_W-1:0] size,
    output logic               iretire_o,
    output logic [IADDR_W-1:0] iaddr_o,
    output logic [ITYPE_W-1:0] itype_o,
    output logic               dretire_o,
    output logic [DTYPE_W-1:0] dtype_o,
    output logic [DADDR_W-1:0] daddr_o,
    output logic [DSIZE_W-1:0] dsize_o
);
    logic is_store;

    always_comb begin
        is_store  = (dir == DIR_PUSH);
        iretire_o = active;
        dretire_o = active;
        iaddr_o   = active ? iaddr : '0;
        itype_o   = (active && is_last) ? ftype : ITYPE_W'(TYPE_PLAIN);
        daddr_o   = active ? daddr : '0;
        dsize_o   = active ? size : '0;
    end

    generate
        if (DTYPE_W == 1) begin : g_kind_narrow
            assign dtype_o = active & is_store;
        end else begin : g_kind_wide
            assign dtype_o = (active && is_store) ? DTYPE_W'(KIND_STORE)
                                                  : DTYPE_W'(KIND_LOAD);
        end
    endgenerate
endmodule

// File: rtl/pushpop_trace_seq.sv
`timescale 1ns/1ps
module pushpop_trace_seq
    import ppseq_pkg::*;
#(
    parameter int IADDR_W = 32,
    parameter int DADDR_W = 32,
    parameter int CNT_W   = 4,
    parameter int ITYPE_W = 4,
    parameter int DTYPE_W = 4,
    parameter int DSIZE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [IADDR_W-1:0] start_iaddr_i,
    input  logic [CNT_W-1:0]   start_count_i,
    input  logic               start_pop_i,
    input  logic [ITYPE_W-1:0] start_ftype_i,
    input  logic [DADDR_W-1:0] start_base_i,
    input  logic [DSIZE_W-1:0] start_size_i,
    input  logic               abort_i,
    output logic               busy_o,
    output logic               iretire_o,
    output logic [IADDR_W-1:0] iaddr_o,
    output logic [ITYPE_W-1:0] itype_o,
    output logic               dretire_o,
    output logic [DTYPE_W-1:0] dtype_o,
    output logic [DADDR_W-1:0] daddr_o,
    output logic [DSIZE_W-1:0] dsize_o
);
    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   done;
        logic [CNT_W-1:0]   total;
        logic [IADDR_W-1:0] iaddr;
        dir_e               dir;
        logic [ITYPE_W-1:0] ftype;
        logic [DADDR_W-1:0] daddr;
        logic [DSIZE_W-1:0] size;
    } seq_t;

    seq_t st_q, st_d;

    dir_e               start_dir;
    logic [DADDR_W-1:0] first_addr;
    logic [DADDR_W-1:0] next_addr;
    logic               is_last;
    logic               active;
    logic               accept;

    assign start_dir = start_pop_i ? DIR_POP : DIR_PUSH;

    ppseq_addr #(
        .ADDR_W (DADDR_W),
        .SIZE_W (DSIZE_W)
    ) u_addr (
        .start_dir  (start_dir),
        .start_size (start_size_i),
        .base       (start_base_i),
        .cur_dir    (st_q.dir),
        .cur_size   (st_q.size),
        .cur        (st_q.daddr),
        .first_addr (first_addr),
        .next_addr  (next_addr)
    );

    ppseq_last #(
        .CNT_W (CNT_W)
    ) u_last (
        .done    (st_q.done),
        .total   (st_q.total),
        .is_last (is_last)
    );

    ppseq_report #(
        .IADDR_W (IADDR_W),
        .DADDR_W (DADDR_W),
        .ITYPE_W (ITYPE_W),
        .DTYPE_W (DTYPE_W),
        .DSIZE_W (DSIZE_W)
    ) u_report (
        .active    (active),
        .is_last   (is_last),
        .dir       (st_q.dir),
        .iaddr     (st_q.iaddr),
        .ftype     (st_q.ftype),
        .daddr     (st_q.daddr),
        .size      (st_q.size),
        .iretire_o (iretire_o),
        .iaddr_o   (iaddr_o),
        .itype_o   (itype_o),
        .dretire_o (dretire_o),
        .dtype_o   (dtype_o),
        .daddr_o   (daddr_o),
        .dsize_o   (dsize_o)
    );

    always_comb begin
        st_d   = st_q;
        active = st_q.busy && !abort_i;
        accept = !st_q.busy && start_i && (start_count_i != '0);

        if (st_q.busy) begin
            if (abort_i) begin
                // trap: drop the series; a re-execution starts over
                st_d.busy = 1'b0;
                st_d.done = '0;
            end else if (is_last) begin
                st_d.busy = 1'b0;
                st_d.done = '0;
            end else begin
                st_d.done  = st_q.done + CNT_W'(1);
                st_d.daddr = next_addr;
            end
        end else if (accept) begin
            st_d.busy  = 1'b1;
            st_d.done  = '0;
            st_d.total = start_count_i;
            st_d.iaddr = start_iaddr_i;
            st_d.dir   = start_dir;
            st_d.ftype = start_ftype_i;
            st_d.daddr = first_addr;
            st_d.size  = start_size_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;

endmodule

// File: rtl/ppseq_checks.sv
`timescale 1ns/1ps
module ppseq_checks #(
    parameter int IADDR_W = 32,
    parameter int DADDR_W = 32,
    parameter int ITYPE_W = 4,
    parameter int DTYPE_W = 4,
    parameter int DSIZE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               abort_i,
    input logic               busy_o,
    input logic               iretire_o,
    input logic [IADDR_W-1:0] iaddr_o,
    input logic [ITYPE_W-1:0] itype_o,
    input logic               dretire_o,
    input logic [DTYPE_W-1:0] dtype_o,
    input logic [DADDR_W-1:0] daddr_o,
    input logic [DSIZE_W-1:0] dsize_o
);
    logic [DADDR_W-1:0] step;
    assign step = DADDR_W'(1) << dsize_o;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!iretire_o && !dretire_o));

    p_strobes_paired_r3: assert property (@(posedge clk) disable iff (!rst_n)
        iretire_o == dretire_o);

    p_same_iaddr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (iretire_o && $past(iretire_o)) |-> (iaddr_o == $past(iaddr_o)));

    p_final_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iretire_o && itype_o != '0) |=> !busy_o);

    p_kind_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (iretire_o && $past(iretire_o)) |-> ($stable(dtype_o) && $stable(dsize_o)));

    p_stride_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iretire_o && $past(iretire_o)) |->
            ((dtype_o == '0) ? (daddr_o == $past(daddr_o) + step)
                             : (daddr_o == $past(daddr_o) - step)));

    p_abort_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && busy_o) |=> !busy_o);

    p_abort_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |-> !iretire_o);
endmodule

bind pushpop_trace_seq ppseq_checks #(
    .IADDR_W (IADDR_W),
    .DADDR_W (DADDR_W),
    .ITYPE_W (ITYPE_W),
    .DTYPE_W (DTYPE_W),
    .DSIZE_W (DSIZE_W)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort_i   (abort_i),
    .busy_o    (busy_o),
    .iretire_o (iretire_o),
    .iaddr_o   (iaddr_o),
    .itype_o   (itype_o),
    .dretire_o (dretire_o),
    .dtype_o   (dtype_o),
    .daddr_o   (daddr_o),
    .dsize_o   (dsize_o)
);

// File: tb/pushpop_trace_seq_tb.sv
`timescale 1ns/1ps
module pushpop_trace_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] iaddr_i = '0;
    logic [3:0]  cnt_i = '0;
    logic        pop_i = 1'b0;
    logic [3:0]  ftype_i = '0;
    logic [31:0] base_i = '0;
    logic [1:0]  size_i = '0;
    logic        abort_i = 1'b0;
    logic        busy_o, iretire_o, dretire_o;
    logic [31:0] iaddr_o, daddr_o;
    logic [3:0]  itype_o, dtype_o;
    logic [1:0]  dsize_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    pushpop_trace_seq u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .start_iaddr_i (iaddr_i), .start_count_i (cnt_i), .start_pop_i (pop_i),
        .start_ftype_i (ftype_i), .start_base_i (base_i), .start_size_i (size_i),
        .abort_i (abort_i), .busy_o (busy_o), .iretire_o (iretire_o),
        .iaddr_o (iaddr_o), .itype_o (itype_o), .dretire_o (dretire_o),
        .dtype_o (dtype_o), .daddr_o (daddr_o), .dsize_o (dsize_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // k-th access address per R6
    function automatic logic [31:0] exp_addr(input bit pop, input int sz,
                                             input logic [31:0] base, input int k);
        logic [31:0] s;
        s = 32'(1) << sz;
        return pop ? base + 32'(k) * s : base - 32'(k + 1) * s;
    endfunction

    task automatic run_seq(input int n, input bit pop, input int sz,
                           input logic [3:0] ft, input logic [31:0] base,
                           input logic [31:0] ia, input int abort_at, input int poke_at);
        @(negedge clk);
        start_i = 1'b1; cnt_i = 4'(n); pop_i = pop; size_i = 2'(sz);
        ftype_i = ft; base_i = base; iaddr_i = ia;
        @(negedge clk);
        start_i = 1'b0; base_i = ~base; iaddr_i = ~ia; pop_i = !pop;
        size_i = ~2'(sz); ftype_i = ~ft;
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge clk);
            abort_i = (k + 1 == abort_at);
            start_i = (k + 1 == poke_at);
            if (start_i) cnt_i = 4'd3;
            #1;
            if (abort_i) begin
                chk("R9 no report on abort", {63'd0, iretire_o}, 64'd0);
                chk("R9 no final type on abort", {60'd0, itype_o}, 64'd0);
                break;
            end
            chk("R2 busy during series", {63'd0, busy_o}, 64'd1);
            chk("R2 report strobe", {63'd0, iretire_o}, 64'd1);
            chk("R3 data strobe", {63'd0, dretire_o}, 64'd1);
            chk("R3 iaddr", {32'd0, iaddr_o}, {32'd0, ia});
            chk("R4 itype", {60'd0, itype_o}, {60'd0, (k == n - 1) ? ft : 4'd0});
            chk("R5 dtype", {60'd0, dtype_o}, pop ? 64'd0 : 64'd1);
            chk("R5 dsize", {62'd0, dsize_o}, 64'(sz));
            chk("R6 daddr", {32'd0, daddr_o}, {32'd0, exp_addr(pop, sz, base, k)});
        end
        @(negedge clk);
        abort_i = 1'b0; start_i = 1'b0;
        #1;
        chk(abort_at != 0 ? "R9 idle after abort" : "R2 idle after last",
            {63'd0, busy_o}, 64'd0);
        chk("R2 no report when idle", {63'd0, iretire_o}, 64'd0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 busy in reset", {63'd0, busy_o}, 64'd0);
        chk("R1 strobe in reset", {63'd0, iretire_o | dretire_o}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 busy after reset", {63'd0, busy_o}, 64'd0);
        chk("R1 strobe after reset", {63'd0, iretire_o | dretire_o}, 64'd0);

        // R2..R6 sweep over count, direction, width
        for (int n = 1; n <= 15; n++)
            for (int p = 0; p < 2; p++)
                for (int sz = 0; sz < 4; sz++)
                    run_seq(n, p[0], sz, p[0] ? 4'd13 : 4'd11,
                            32'h8000_0000 + 32'(n * 256), 32'h1000 + 32'(n * 2), 0, 0);

        // R6 wrap below zero
        run_seq(5, 1'b0, 3, 4'd0, 32'h0000_0010, 32'h2000, 0, 0);

        // R7 start pokes while busy
        run_seq(6, 1'b1, 2, 4'd13, 32'h4000, 32'h3000, 0, 2);
        run_seq(4, 1'b0, 2, 4'd9, 32'h4000, 32'h3004, 0, 4);

        // R8 zero count
        @(negedge clk);
        start_i = 1'b1; cnt_i = 4'd0; pop_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        chk("R8 busy stays low", {63'd0, busy_o}, 64'd0);
        chk("R8 no report", {63'd0, iretire_o}, 64'd0);
        @(negedge clk);
        #1;
        chk("R8 still idle", {63'd0, busy_o | iretire_o}, 64'd0);

        // R9 abort mid-series, then restart from access 1
        run_seq(6, 1'b1, 2, 4'd13, 32'h5000, 32'h3100, 3, 0);
        run_seq(6, 1'b1, 2, 4'd13, 32'h5000, 32'h3100, 0, 0);
        // R9 abort on the final access suppresses the natural type
        run_seq(4, 1'b0, 3, 4'd13, 32'h6000, 32'h3200, 4, 0);
        run_seq(4, 1'b0, 3, 4'd13, 32'h6000, 32'h3200, 1, 0);
        run_seq(4, 1'b0, 3, 4'd13, 32'h6000, 32'h3200, 0, 0);

        done_flag = 1;
        summary();
    end
endmodule